// File: doc/BRIEF.md
# Memory Activity Monitor Counter

This block watches memory traffic on a number of independent channels. Each channel receives one pulse per group of bus transactions and adds a programmable weight to a running count for every pulse. A shared millisecond tick drives one global period timer. When a period closes, every running channel captures its count and clears it. It then folds the captured sample into an exponential moving average and compares both the raw sample and the new average against their own pairs of watermarks.

A raw-watermark breach raises its sticky status flag only after a programmed number of consecutive breaching periods. An average breach raises its flag at once. Each channel drives an interrupt line that is the OR of its enabled flags. The block's single `irq` output is the OR of all channels, and a global status word shows which channel is asserting.

Each channel is a four-state machine:
- `CH_OFF`: the channel enable bit is clear.
- `CH_IDLE`: the channel is enabled but periodic sampling is off.
- `CH_RUN`: the channel is counting.
- `CH_EVAL`: a one-cycle state in which the average and the flags are updated.

The transitions are:
- off→idle or off→run on enable, with periodic sampling choosing which;
- idle→run when periodic sampling is set;
- run→idle when periodic sampling is cleared;
- run→eval when a period ends;
- eval→run, or eval→idle if periodic sampling has been cleared;
- any state→off when the enable is cleared.

Address map. The global registers sit at base 0x00: status at 0x00 (read only) and period at 0x04. Channel c sits at base 0x40·(c+1), with these offsets:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | raw upper watermark |
| 0x08 | raw lower watermark |
| 0x0C | average load |
| 0x10 | average upper watermark |
| 0x14 | average lower watermark |
| 0x18 | weight |
| 0x20 | average readback |
| 0x24 | status |

Top module: `mem_activity_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Bits [PER_W-1:0] of the global period register hold P. A period closes on the (P+1)-th `ms_tick` since the previous close, and on no earlier tick.
- R3: While running, each cycle with the channel's event pulse high adds the weight register to the count. A period close captures the count as the sample and clears the count, so each sample holds only that period's events.
- R4: Control bits [12:10] hold K. At each close the average becomes avg + ((sample − avg) >>> (K+1)), with the difference signed, so the averaging window is 2^(K+1) samples.
- R5: A write to the average-load register sets the average, and the average readback returns it.
- R6: A sample strictly greater than the raw upper watermark is an above-breach. When control bits [28:26] hold A, status bit 31 sets on the (A+1)-th consecutive above-breach, and the streak count then restarts at zero.
- R7: A sample strictly less than the raw lower watermark is a below-breach. When control bits [25:23] hold B, status bit 30 sets on the (B+1)-th consecutive below-breach, and that streak count then restarts.
- R8: A closed period that does not breach a watermark resets that watermark's streak count.
- R9: At a close, status bit 29 sets if the new average is strictly greater than the average upper watermark, and bit 28 sets if it is strictly less than the average lower watermark.
- R10: Status flags stay set until cleared. Writing a 1 to a status bit clears only that bit, so writing all ones clears every flag.
- R11: Control bits 30, 29, 21 and 20 enable status bits 31, 30, 29 and 28 respectively. A channel interrupts when any enabled flag is set. Global status bit c shows channel c's interrupt, and `irq` is the OR of all channels.
- R12: With control bit 31 (enable) clear, or with control bit 18 (periodic) clear, events are not counted and a period close leaves the average and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pulse | input | NUM_CH | One activity event per channel per cycle high |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| irq | output | 1 | OR of all channel interrupts |

## Verification
Timing is counted from the clock edge that samples the `ms_tick` that closes a period, called edge T:
- the timer raises its period-end pulse after edge T;
- the channel captures its count and enters `CH_EVAL` at edge T+1;
- the average, the status flags, the global status and `irq` take their new values at edge T+2.

The bench drives each closing tick, then waits exactly two more rising edges and reads the results on the following falling edge. Register writes take effect at the next rising edge. Each burst of events is started one idle cycle after the last control write, so that the channel has already left `CH_OFF` or `CH_IDLE`. The period rule is checked by reading the average one tick before the close and again on the close.

// File: rtl/amon_pkg.sv
package amon_pkg;
    localparam int REG_W  = 32;
    localparam int OFS_W  = 6;
    localparam int KF_W   = 3;
    localparam int CNTF_W = 3;

    localparam logic [OFS_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [OFS_W-1:0] OFS_UPWM = 6'h04;
    localparam logic [OFS_W-1:0] OFS_LOWM = 6'h08;
    localparam logic [OFS_W-1:0] OFS_LOAD = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_AUPW = 6'h10;
    localparam logic [OFS_W-1:0] OFS_ALOW = 6'h14;
    localparam logic [OFS_W-1:0] OFS_WGHT = 6'h18;
    localparam logic [OFS_W-1:0] OFS_AVGR = 6'h20;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h24;
    localparam logic [OFS_W-1:0] OFS_GSTAT = 6'h00;
    localparam logic [OFS_W-1:0] OFS_GPER  = 6'h04;

    localparam int CTL_ON       = 31;
    localparam int CTL_CUP_IE   = 30;
    localparam int CTL_CLO_IE   = 29;
    localparam int CTL_UPN_LSB  = 26;
    localparam int CTL_LON_LSB  = 23;
    localparam int CTL_AUP_IE   = 21;
    localparam int CTL_ALO_IE   = 20;
    localparam int CTL_PERIODIC = 18;
    localparam int CTL_K_LSB    = 10;

    localparam int FLG_LSB = 28;
    localparam int FLG_W   = 4;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_IDLE = 2'd1,
        CH_RUN  = 2'd2,
        CH_EVAL = 2'd3
    } ch_state_e;
endpackage

// File: rtl/amon_period_timer.sv
module amon_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [PER_W-1:0] per_lim,
    output logic             period_end
);
    logic [PER_W-1:0] ms_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_cnt_q   <= '0;
            period_end <= 1'b0;
        end else begin
            period_end <= 1'b0;
            if (ms_tick) begin
                if (ms_cnt_q >= per_lim) begin
                    ms_cnt_q   <= '0;
                    period_end <= 1'b1;
                end else begin
                    ms_cnt_q <= ms_cnt_q + 1'b1;
                end
            end
        end
    end

    // R2: a period can only close right after a tick
    p_end_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |-> $past(ms_tick));
endmodule

// File: rtl/amon_streak.sv
module amon_streak #(
    parameter int NUM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             breach,
    input  logic [NUM_W-1:0] lim,
    output logic             fire
);
    logic [NUM_W-1:0] run_q;

    assign fire = step && breach && !clr && (run_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr) begin
            run_q <= '0;
        end else if (step) begin
            if (!breach || fire) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R6/R7: the streak restarts once it has fired
    p_streak_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (run_q == '0));
    // R8: a quiet period breaks the streak
    p_streak_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !breach) |=> (run_q == '0));
endmodule

// File: rtl/amon_channel.sv
module amon_channel
    import amon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic             ev_pulse,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wofs,
    input  logic [REG_W-1:0] wdata,
    input  logic [OFS_W-1:0] rofs,
    output logic [REG_W-1:0] rd_val,
    output logic             ch_irq
);
    ch_state_e st_q, st_d;

    logic [REG_W-1:0] ctrl_q, upwm_q, lowm_q, aupw_q, alow_q, wght_q;
    logic [REG_W-1:0] avg_q, count_q, sample_q;
    logic [FLG_W-1:0] flag_q;

    logic ch_on, periodic;
    logic [KF_W-1:0]   k_val;
    logic [CNTF_W-1:0] up_need, lo_need;

    assign ch_on    = ctrl_q[CTL_ON];
    assign periodic = ctrl_q[CTL_PERIODIC];
    assign k_val    = ctrl_q[CTL_K_LSB +: KF_W];
    assign up_need  = ctrl_q[CTL_UPN_LSB +: CNTF_W];
    assign lo_need  = ctrl_q[CTL_LON_LSB +: CNTF_W];

    logic wr_ctrl, wr_load, wr_stat;
    assign wr_ctrl = wr_en && (wofs == OFS_CTRL);
    assign wr_load = wr_en && (wofs == OFS_LOAD);
    assign wr_stat = wr_en && (wofs == OFS_STAT);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF:  if (ch_on) st_d = periodic ? CH_RUN : CH_IDLE;
            CH_IDLE: if (!ch_on) st_d = CH_OFF;
                     else if (periodic) st_d = CH_RUN;
            CH_RUN:  if (!ch_on) st_d = CH_OFF;
                     else if (!periodic) st_d = CH_IDLE;
                     else if (period_end) st_d = CH_EVAL;
            CH_EVAL: if (!ch_on) st_d = CH_OFF;
                     else st_d = periodic ? CH_RUN : CH_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    logic cnt_en, cap_stb, eval_stb;
    always_comb begin
        cnt_en   = 1'b0;
        cap_stb  = 1'b0;
        eval_stb = 1'b0;
        unique case (st_q)
            CH_OFF:  ;
            CH_IDLE: ;
            CH_RUN:  begin
                cnt_en  = 1'b1;
                cap_stb = (st_d == CH_EVAL);
            end
            CH_EVAL: begin
                cnt_en   = 1'b1;
                eval_stb = 1'b1;
            end
        endcase
    end

    // ---------------- average arithmetic ----------------
    logic signed [REG_W:0] gap, gap_sh;
    logic [REG_W-1:0] avg_new;
    assign gap     = $signed({1'b0, sample_q}) - $signed({1'b0, avg_q});
    assign gap_sh  = gap >>> ({1'b0, k_val} + 4'd1);
    assign avg_new = avg_q + REG_W'(gap_sh);

    // ---------------- consecutive-breach trackers ----------------
    logic up_fire, lo_fire;
    amon_streak #(.NUM_W(CNTF_W)) u_up_streak (
        .clk(clk), .rst_n(rst_n), .clr(st_q == CH_OFF), .step(eval_stb),
        .breach(sample_q > upwm_q), .lim(up_need), .fire(up_fire)
    );
    amon_streak #(.NUM_W(CNTF_W)) u_lo_streak (
        .clk(clk), .rst_n(rst_n), .clr(st_q == CH_OFF), .step(eval_stb),
        .breach(sample_q < lowm_q), .lim(lo_need), .fire(lo_fire)
    );

    logic [FLG_W-1:0] flag_set, flag_clr;
    assign flag_set = {up_fire, lo_fire,
                       eval_stb && (avg_new > aupw_q),
                       eval_stb && (avg_new < alow_q)};
    assign flag_clr = wr_stat ? wdata[FLG_LSB +: FLG_W] : '0;

    logic [REG_W-1:0] ev_add;
    assign ev_add = ev_pulse ? wght_q : '0;

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            upwm_q   <= '0;
            lowm_q   <= '0;
            aupw_q   <= '0;
            alow_q   <= '0;
            wght_q   <= '0;
            avg_q    <= '0;
            count_q  <= '0;
            sample_q <= '0;
            flag_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_en && wofs == OFS_UPWM) upwm_q <= wdata;
            if (wr_en && wofs == OFS_LOWM) lowm_q <= wdata;
            if (wr_en && wofs == OFS_AUPW) aupw_q <= wdata;
            if (wr_en && wofs == OFS_ALOW) alow_q <= wdata;
            if (wr_en && wofs == OFS_WGHT) wght_q <= wdata;

            if (cap_stb)     count_q <= ev_add;
            else if (cnt_en) count_q <= count_q + ev_add;
            else             count_q <= '0;

            if (cap_stb) sample_q <= count_q;

            if (wr_load)       avg_q <= wdata;
            else if (eval_stb) avg_q <= avg_new;

            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    // ---------------- readback and interrupt ----------------
    always_comb begin
        case (rofs)
            OFS_CTRL: rd_val = ctrl_q;
            OFS_UPWM: rd_val = upwm_q;
            OFS_LOWM: rd_val = lowm_q;
            OFS_AUPW: rd_val = aupw_q;
            OFS_ALOW: rd_val = alow_q;
            OFS_WGHT: rd_val = wght_q;
            OFS_AVGR: rd_val = avg_q;
            OFS_STAT: rd_val = {flag_q, {FLG_LSB{1'b0}}};
            default:  rd_val = '0;
        endcase
    end

    assign ch_irq = |(flag_q & {ctrl_q[CTL_CUP_IE], ctrl_q[CTL_CLO_IE],
                                ctrl_q[CTL_AUP_IE], ctrl_q[CTL_ALO_IE]});

    // R3: evaluation only follows a period close
    p_eval_after_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_EVAL) |-> $past(period_end));
    // R12: a disabled channel holds no count
    p_off_no_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF) |=> (count_q == '0));
    // R12: without sampling the average only moves on a load write
    p_idle_avg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !wr_load) |=> $stable(avg_q));
    // R10: the consecutive-upper flag stays set until written with a one
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q[FLG_W-1]) && !$past(wr_stat && wdata[REG_W-1])) |-> flag_q[FLG_W-1]);
endmodule

// File: rtl/mem_activity_monitor.sv
module mem_activity_monitor
    import amon_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] ev_pulse,
    input  logic              ms_tick,
    output logic              irq
);
    localparam int SEL_W = ADDR_W - OFS_W;

    logic [SEL_W-1:0] sel;
    logic [OFS_W-1:0] ofs;
    assign sel = reg_addr[ADDR_W-1:OFS_W];
    assign ofs = reg_addr[OFS_W-1:0];

    logic [PER_W-1:0] per_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else if (reg_wr && sel == '0 && ofs == OFS_GPER) per_q <= reg_wdata[PER_W-1:0];
    end

    logic period_end;
    amon_period_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .per_lim(per_q), .period_end(period_end)
    );

    logic [REG_W-1:0] ch_rd [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        amon_channel u_ch (
            .clk(clk), .rst_n(rst_n), .period_end(period_end),
            .ev_pulse(ev_pulse[c]),
            .wr_en(reg_wr && (sel == SEL_W'(c + 1))),
            .wofs(ofs), .wdata(reg_wdata), .rofs(ofs),
            .rd_val(ch_rd[c]), .ch_irq(ch_irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (sel == '0) begin
            if (ofs == OFS_GSTAT)     reg_rdata = REG_W'(ch_irq);
            else if (ofs == OFS_GPER) reg_rdata = REG_W'(per_q);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel == SEL_W'(c + 1)) reg_rdata = ch_rd[c];
        end
    end

    assign irq = |ch_irq;
endmodule

// File: tb/tb_mem_activity_monitor.sv
module tb_mem_activity_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ev_pulse = '0;
    logic        ms_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_activity_monitor #(.NUM_CH(2), .ADDR_W(8), .PER_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .ms_tick(ms_tick), .irq(irq)
    );

    localparam int N_VEC = 14;
    // {events in period, expect consecutive-upper flag, expect consecutive-lower flag}
    localparam logic [7:0] VEC [N_VEC] = '{
        {6'd12, 1'b0, 1'b0}, {6'd12, 1'b1, 1'b0}, {6'd12, 1'b0, 1'b0},
        {6'd5,  1'b0, 1'b0}, {6'd12, 1'b0, 1'b0}, {6'd12, 1'b1, 1'b0},
        {6'd1,  1'b0, 1'b0}, {6'd1,  1'b0, 1'b0}, {6'd1,  1'b0, 1'b1},
        {6'd2,  1'b0, 1'b0}, {6'd5,  1'b0, 1'b0}, {6'd0,  1'b0, 1'b0},
        {6'd0,  1'b0, 1'b0}, {6'd0,  1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int ch, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev_pulse[ch] = 1'b1;
            @(negedge clk); ev_pulse[ch] = 1'b0;
        end
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int mavg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h40, v); check("R1 ch0 control", v, 32'h0);
        rd(8'h60, v); check("R1 ch0 average", v, 32'h0);
        rd(8'h00, v); check("R1 global status", v, 32'h0);
        rd(8'h04, v); check("R1 period", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R5 average load
        wr(8'h4C, 32'd20);
        rd(8'h60, v); check("R5 ch0 load", v, 32'd20);

        // channel 0 setup: weight 4, raw wm 40/12, avg wm 1000/0, K=0, A=1, B=2
        wr(8'h04, 32'd1);
        wr(8'h58, 32'd4);
        wr(8'h44, 32'd40);
        wr(8'h48, 32'd12);
        wr(8'h50, 32'd1000);
        wr(8'h54, 32'd0);
        wr(8'h40, (32'd1 << 31) | (32'd1 << 30) | (32'd1 << 29) | (32'd1 << 18) |
                  (32'd1 << 26) | (32'd2 << 23));

        mavg = 20;
        for (int i = 0; i < N_VEC; i++) begin
            int ev;
            logic [31:0] exp_st;
            ev = int'(VEC[i][7:2]);
            pulse(0, ev);
            tick();
            tick();
            settle();
            mavg = mavg + (((ev * 4) - mavg) >>> 1);
            exp_st = {VEC[i][1], VEC[i][0], 30'b0};
            rd(8'h60, v); check("R4 R3 table average", v, 32'(mavg));
            rd(8'h64, v); check("R6 R7 R8 table status", v, exp_st);
            check("R11 table irq", {31'b0, irq}, {31'b0, VEC[i][1] | VEC[i][0]});
            wr(8'h64, 32'hFFFF_FFFF);
        end

        wr(8'h40, 32'h0);
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h64, v); check("R10 all-ones clear", v, 32'h0);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);

        // channel 1: load, disabled, then sampling off
        wr(8'hA0 - 8'h14, 32'd100);
        rd(8'hA0, v); check("R5 ch1 load", v, 32'd100);
        wr(8'h98, 32'd10);
        pulse(1, 3); tick(); tick(); settle();
        rd(8'hA0, v); check("R12 disabled avg hold", v, 32'd100);
        wr(8'h80, (32'd1 << 31) | (32'd1 << 10));
        pulse(1, 5); tick(); tick(); settle();
        rd(8'hA0, v); check("R12 periodic off avg hold", v, 32'd100);
        rd(8'hA4, v); check("R12 periodic off status", v, 32'h0);

        // R9 average above, K=1
        wr(8'h84, 32'd0);
        wr(8'h88, 32'd0);
        wr(8'h90, 32'd110);
        wr(8'h94, 32'd50);
        wr(8'h80, (32'd1 << 31) | (32'd1 << 18) | (32'd1 << 10) | (32'd1 << 21));
        pulse(1, 30); tick(); tick(); settle();
        rd(8'hA0, v); check("R4 ch1 average K=1", v, 32'd150);
        rd(8'hA4, v); check("R9 R6 above status", v, 32'hA000_0000);
        check("R11 irq enabled avg-above", {31'b0, irq}, 32'h1);
        rd(8'h00, v); check("R11 global status ch1", v, 32'h2);

        wr(8'hA4, 32'hFFFF_FFFF);
        check("R10 irq cleared", {31'b0, irq}, 32'h0);
        wr(8'h94, 32'd120);
        pulse(1, 0); tick(); tick(); settle();
        rd(8'hA0, v); check("R4 negative step floor", v, 32'd112);
        rd(8'hA4, v); check("R9 both avg flags", v, 32'h3000_0000);

        // R2 three-tick period
        wr(8'hA4, 32'hFFFF_FFFF);
        wr(8'h04, 32'd2);
        pulse(1, 10); tick(); tick(); settle();
        rd(8'hA0, v); check("R2 no close before third tick", v, 32'd112);
        rd(8'hA4, v); check("R2 no flags before close", v, 32'h0);
        tick(); settle();
        rd(8'hA0, v); check("R2 close on third tick", v, 32'd109);
        rd(8'hA4, v); check("R9 R6 status after close", v, 32'h9000_0000);

        wr(8'hA4, 32'h8000_0000);
        rd(8'hA4, v); check("R10 single-bit clear", v, 32'h1000_0000);
        check("R11 masked below-avg", {31'b0, irq}, 32'h0);
        rd(8'h00, v); check("R11 global status masked", v, 32'h0);
        wr(8'h80, (32'd1 << 31) | (32'd1 << 18) | (32'd1 << 10) | (32'd1 << 21) | (32'd1 << 20));
        check("R11 enabled below-avg", {31'b0, irq}, 32'h1);
        rd(8'h00, v); check("R11 global status unmasked", v, 32'h2);

        done = 1'b1;
        finish_run();
    end
endmodule